// File: doc/BRIEF.md
# Guard-Bit Sign-Magnitude Accumulator

This block is the arithmetic register of a word machine whose numbers are in sign-magnitude form. A memory word holds a sign and a magnitude. The accumulator adds guard bits between the sign and the top magnitude bit. With the default parameters this gives a 36-bit word and a 38-bit accumulator. A carry that leaves the top magnitude bit during an add is kept in the guard bits and is not lost.

Each clock cycle the unit takes one command on a small opcode input. The commands are: no operation, clear, arithmetic load, logical load, add, subtract, arithmetic store, logical store, and test-and-clear of the sticky overflow flag. The two load paths place a word in different ways. An arithmetic load keeps the word's sign in the accumulator sign. A logical load treats the word's leftmost bit as data and puts it into the lower guard bit (P). The two store paths take the word back out of the matching positions.

Top module: `gacc_unit`

## Requirements
- R1: After reset the accumulator, the stored-word output and the overflow flag are all zero.
- R2: The opcodes are NOP=0, CLR=1, LDA=2, LDL=3, ADD=4, SUB=5, STA=6, STL=7 and TOV=8. NOP leaves every output unchanged. CLR zeroes the accumulator and leaves the overflow flag unchanged.
- R3: The accumulator layout is: bit 37 is the sign S, bit 36 is Q, bit 35 is P, and bits 34..0 are the magnitude, with bit 34 the most significant. A word has its sign in bit 35 and its magnitude in bits 34..0. LDA copies the word sign to S and the word magnitude to the magnitude bits, and clears Q and P.
- R4: LDL copies word bit 35 to P and the word magnitude to the magnitude bits, and clears S and Q.
- R5: ADD with equal signs adds the word magnitude to the 37-bit accumulator magnitude {Q,P,magnitude} and keeps the sign.
- R6: ADD with different signs subtracts the smaller magnitude from the larger. The result takes the sign of the larger operand.
- R7: SUB behaves as ADD with the word sign inverted. A result of zero magnitude keeps the accumulator's sign.
- R8: The overflow flag is set when a carry leaves the top magnitude bit into P, including when that carry ripples on into Q. Once set, it stays set through any other command.
- R9: During a TOV cycle the output ovf_ret_o equals the flag. The flag is zero after that edge.
- R10: STA drives {S, magnitude} onto the word output after the edge and leaves the accumulator unchanged.
- R11: STL drives {P, magnitude} onto the word output after the edge and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Command for this cycle |
| word_i | input | 36 | Memory word operand |
| acc_o | output | 38 | Accumulator contents S,Q,P,magnitude |
| word_o | output | 36 | Last stored word |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_ret_o | output | 1 | Flag value returned by TOV |

## Verification
The bench builds the unit with its default widths: a 35-bit magnitude and two guard bits. Because of this, an all-ones magnitude plus one carries across the full magnitude chain into P. A logical load that sets P, followed by the same add, carries all the way through P into Q. The defaults also cover the equal-magnitude subtract that keeps the sign of the accumulator.

// File: rtl/gacc_pkg.sv
package gacc_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP = 4'd0,
      OP_CLR = 4'd1,
      OP_LDA = 4'd2,
      OP_LDL = 4'd3,
      OP_ADD = 4'd4,
      OP_SUB = 4'd5,
      OP_STA = 4'd6,
      OP_STL = 4'd7,
      OP_TOV = 4'd8
   } op_e;
endpackage

// File: rtl/gacc_addsub.sv
// Sign-magnitude add/subtract over the guard-extended magnitude.
module gacc_addsub #(
   parameter int MAG_W   = 35,
   parameter int GUARD_W = 2,
   localparam int GM_W   = GUARD_W + MAG_W
) (
   input  logic             a_sign,
   input  logic [GM_W-1:0]  a_mag,
   input  logic             w_sign,
   input  logic [MAG_W-1:0] w_mag,
   input  logic             negate,
   output logic             r_sign,
   output logic [GM_W-1:0]  r_mag,
   output logic             carry_guard
);
   logic              eff_sign;
   logic [MAG_W:0]    lo_sum;
   logic [GUARD_W-1:0] hi_sum;
   logic [GM_W-1:0]   w_ext;

   assign eff_sign = w_sign ^ negate;
   assign w_ext    = {{GUARD_W{1'b0}}, w_mag};
   assign lo_sum   = {1'b0, a_mag[MAG_W-1:0]} + {1'b0, w_mag};
   assign hi_sum   = a_mag[GM_W-1:MAG_W] + GUARD_W'(lo_sum[MAG_W]);

   always_comb begin
      carry_guard = 1'b0;
      if (eff_sign == a_sign) begin
         r_mag       = {hi_sum, lo_sum[MAG_W-1:0]};
         r_sign      = a_sign;
         carry_guard = lo_sum[MAG_W];
      end else if (a_mag >= w_ext) begin
         // equal magnitudes land here: zero keeps the accumulator sign
         r_mag  = a_mag - w_ext;
         r_sign = a_sign;
      end else begin
         r_mag  = w_ext - a_mag;
         r_sign = eff_sign;
      end
   end
endmodule

// File: rtl/gacc_fmt.sv
// Word placement for the two load paths and the two store paths.
module gacc_fmt #(
   parameter int MAG_W   = 35,
   parameter int GUARD_W = 2,
   localparam int WORD_W = MAG_W + 1,
   localparam int ACC_W  = 1 + GUARD_W + MAG_W
) (
   input  logic              logical,
   input  logic [WORD_W-1:0] word,
   input  logic [ACC_W-1:0]  acc,
   output logic [ACC_W-1:0]  load_val,
   output logic [WORD_W-1:0] store_val
);
   localparam int P_BIT = MAG_W;
   localparam int S_BIT = ACC_W - 1;

   generate
      if (GUARD_W > 1) begin : g_wide
         assign load_val = logical
            ? {1'b0, {(GUARD_W-1){1'b0}}, word[WORD_W-1], word[MAG_W-1:0]}
            : {word[WORD_W-1], {GUARD_W{1'b0}}, word[MAG_W-1:0]};
      end else begin : g_single
         assign load_val = logical
            ? {1'b0, word[WORD_W-1], word[MAG_W-1:0]}
            : {word[WORD_W-1], 1'b0, word[MAG_W-1:0]};
      end
   endgenerate

   assign store_val = logical ? {acc[P_BIT], acc[MAG_W-1:0]}
                              : {acc[S_BIT], acc[MAG_W-1:0]};
endmodule

// File: rtl/gacc_unit.sv
module gacc_unit #(
   parameter int MAG_W   = 35,
   parameter int GUARD_W = 2,
   localparam int WORD_W = MAG_W + 1,
   localparam int ACC_W  = 1 + GUARD_W + MAG_W,
   localparam int GM_W   = GUARD_W + MAG_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [gacc_pkg::OP_W-1:0]  op_i,
   input  logic [WORD_W-1:0]          word_i,
   output logic [ACC_W-1:0]           acc_o,
   output logic [WORD_W-1:0]          word_o,
   output logic                       ovf_o,
   output logic                       ovf_ret_o
);
   import gacc_pkg::*;

   initial begin
      if (MAG_W < 2)   $error("MAG_W must be at least 2");
      if (GUARD_W < 1) $error("GUARD_W must be at least 1");
   end

   localparam int S_BIT = ACC_W - 1;

   op_e                op;
   logic [ACC_W-1:0]   acc_q;
   logic [WORD_W-1:0]  word_q;
   logic               ovf_q;
   logic [ACC_W-1:0]   load_val;
   logic [WORD_W-1:0]  store_val;
   logic               r_sign;
   logic [GM_W-1:0]    r_mag;
   logic               carry_guard;

   assign op = op_e'(op_i);

   gacc_fmt #(.MAG_W(MAG_W), .GUARD_W(GUARD_W)) u_fmt (
      .logical   (op == OP_LDL || op == OP_STL),
      .word      (word_i),
      .acc       (acc_q),
      .load_val  (load_val),
      .store_val (store_val)
   );

   gacc_addsub #(.MAG_W(MAG_W), .GUARD_W(GUARD_W)) u_addsub (
      .a_sign      (acc_q[S_BIT]),
      .a_mag       (acc_q[GM_W-1:0]),
      .w_sign      (word_i[WORD_W-1]),
      .w_mag       (word_i[MAG_W-1:0]),
      .negate      (op == OP_SUB),
      .r_sign      (r_sign),
      .r_mag       (r_mag),
      .carry_guard (carry_guard)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         word_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         case (op)
            OP_CLR:         acc_q <= '0;
            OP_LDA, OP_LDL: acc_q <= load_val;
            OP_ADD, OP_SUB: begin
               acc_q <= {r_sign, r_mag};
               if (carry_guard) ovf_q <= 1'b1;
            end
            OP_STA, OP_STL: word_q <= store_val;
            OP_TOV:         ovf_q  <= 1'b0;
            default: ;
         endcase
      end
   end

   assign acc_o     = acc_q;
   assign word_o    = word_q;
   assign ovf_o     = ovf_q;
   assign ovf_ret_o = (op == OP_TOV) & ovf_q;

   p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'd1 |=> acc_o == '0);
   p_arith_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'd2 |=> acc_o == {$past(word_i[WORD_W-1]), {GUARD_W{1'b0}}, $past(word_i[MAG_W-1:0])});
   p_logic_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'd3 |=> !acc_o[S_BIT] && !acc_o[GM_W-1] && acc_o[MAG_W] == $past(word_i[WORD_W-1]));
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o && op_i != 4'd8 |=> ovf_o);
   p_tov_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'd8 |=> !ovf_o);
   p_store_keeps_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd6 || op_i == 4'd7) |=> $stable(acc_o));
endmodule

// File: tb/gacc_unit_bench.sv
module gacc_unit_bench;
   localparam logic [34:0] ONES = {35{1'b1}};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = 4'd0;
   logic [35:0] word_i = '0;
   logic [37:0] acc_o;
   logic [35:0] word_o;
   logic        ovf_o, ovf_ret_o;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gacc_unit u_gacc_unit (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .word_i(word_i),
      .acc_o(acc_o), .word_o(word_o), .ovf_o(ovf_o), .ovf_ret_o(ovf_ret_o));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] op, input logic [35:0] w);
      @(negedge clk);
      op_i = op; word_i = w;
      @(negedge clk);
      op_i = 4'd0;
   endtask

   task automatic t_reset();
      check("R1 acc", 64'(acc_o), 64'd0);
      check("R1 word", 64'(word_o), 64'd0);
      check("R1 ovf", 64'(ovf_o), 64'd0);
   endtask

   task automatic t_loads();
      issue(4'd2, {1'b1, 35'h5});
      check("R3 arith load", 64'(acc_o), 64'({1'b1, 2'b00, 35'h5}));
      issue(4'd3, {1'b1, 35'h7});
      check("R4 logical load", 64'(acc_o), 64'({1'b0, 1'b0, 1'b1, 35'h7}));
   endtask

   task automatic t_arith();
      issue(4'd2, {1'b0, 35'd100});
      issue(4'd4, {1'b0, 35'd23});
      check("R5 like add", 64'(acc_o), 64'({1'b0, 2'b00, 35'd123}));
      issue(4'd4, {1'b1, 35'd200});
      check("R6 unlike add", 64'(acc_o), 64'({1'b1, 2'b00, 35'd77}));
      issue(4'd5, {1'b1, 35'd77});
      check("R7 zero keeps sign", 64'(acc_o), 64'({1'b1, 37'd0}));
      issue(4'd2, {1'b1, 35'd5});
      issue(4'd5, {1'b0, 35'd3});
      check("R7 sub negative", 64'(acc_o), 64'({1'b1, 2'b00, 35'd8}));
      check("R8 no ovf", 64'(ovf_o), 64'd0);
   endtask

   task automatic t_overflow();
      issue(4'd2, {1'b0, ONES});
      issue(4'd4, {1'b0, 35'd1});
      check("R8 carry into P", 64'(acc_o), 64'({1'b0, 2'b01, 35'd0}));
      check("R8 ovf set", 64'(ovf_o), 64'd1);
      issue(4'd4, {1'b0, ONES});
      issue(4'd1, 36'd0);
      check("R2 clr acc", 64'(acc_o), 64'd0);
      check("R8 sticky", 64'(ovf_o), 64'd1);
      issue(4'd0, {1'b1, ONES});
      check("R2 nop", 64'(acc_o), 64'd0);
   endtask

   task automatic t_tov();
      @(negedge clk);
      op_i = 4'd8;
      #1 check("R9 ret high", 64'(ovf_ret_o), 64'd1);
      @(negedge clk);
      op_i = 4'd0;
      check("R9 cleared", 64'(ovf_o), 64'd0);
      @(negedge clk);
      op_i = 4'd8;
      #1 check("R9 ret low", 64'(ovf_ret_o), 64'd0);
      @(negedge clk);
      op_i = 4'd0;
   endtask

   task automatic t_carry_q();
      issue(4'd3, {1'b1, ONES});
      issue(4'd4, {1'b0, 35'd1});
      check("R8 carry into Q", 64'(acc_o), 64'({1'b0, 2'b10, 35'd0}));
      check("R8 ovf via Q", 64'(ovf_o), 64'd1);
   endtask

   task automatic t_store();
      issue(4'd2, {1'b1, 35'h1234});
      issue(4'd3, {1'b1, ONES});
      issue(4'd6, 36'd0);
      check("R10 arith store", 64'(word_o), 64'({1'b0, ONES}));
      check("R10 acc kept", 64'(acc_o), 64'({1'b0, 2'b01, ONES}));
      issue(4'd7, 36'd0);
      check("R11 logical store", 64'(word_o), 64'({1'b1, ONES}));
      check("R11 acc kept", 64'(acc_o), 64'({1'b0, 2'b01, ONES}));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_loads();
      t_arith();
      t_overflow();
      t_tov();
      t_carry_q();
      t_store();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule